// File: doc/BRIEF.md
# Timer Counter Channel with Clock-Source and Clear Selection

This block is one channel of a general-purpose timer. A 16-bit up counter advances on a count tick, and a small control register chooses where that tick comes from: one of four internal prescaled clocks, or one of four external clock pins with a selectable active edge. The same register chooses what resets the counter. It can be left free-running, cleared by an event on general register A, cleared by an event on general register B, or cleared together with peer channels through a shared clear line.

Each of the two general registers has its own role input. In compare mode the register is compared against the counter, and reaching it raises a match flag. In capture mode a strobe copies the counter into the register. When the selected register causes a clear, the channel drives a clear-event pulse that peer channels in synchronized-clear mode can use. A phase-counting flag hands the count tick to an external quadrature decoder, and the prescaler and edge fields then have no effect.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `tcnt` is 0, `cfg_rdata` is 0x00, both general registers hold 0xFFFF, and `cmp_match` and `clr_evt` are low.
- R2: A write with `cfg_we` loads `cfg_wdata`. Bits 2:0 are the prescaler field, bits 4:3 the edge field and bits 6:5 the clear field. `cfg_rdata` returns these seven bits with bit 7 always 0.
- R3: With prescaler bit 2 at 0, the tick comes from `int_clk[psc[1:0]]`. Only a 1-to-0 change between two consecutive clock samples counts, and unselected pins have no effect.
- R4: With prescaler bit 2 at 1, the tick comes from `ext_clk[psc[1:0]]` after a two-stage synchronizer. Edge field 00 counts rising edges, 01 counts falling edges, and 10 or 11 count both.
- R5: While `phase_mode` is 1, the counter advances only on `phase_tick`. The prescaler and edge fields, and any change to them, do not affect counting.
- R6: Each tick adds 1 to `tcnt`, 0xFFFF wraps to 0x0000, and without a tick or a clear the counter holds.
- R7: With clear field 00, nothing clears the counter.
- R8: In compare mode (`gr_cap_mode[i]`=0), `cmp_match[i]` is high while `tcnt` equals the register. With clear field 01 (A) or 10 (B), a tick arriving while the selected register matches loads 0 in place of the increment.
- R9: In capture mode, a `cap_strobe[i]` pulse loads the pre-clear value of `tcnt` into that register. If the clear field selects that register, the counter becomes 0 on the same edge. In capture mode `cmp_match[i]` stays low.
- R10: With clear field 11, a `sync_clr_in` pulse makes `tcnt` 0 on the next edge and `clr_evt` stays low. Under any other clear field, `sync_clr_in` is ignored.
- R11: `clr_evt` is high in exactly the cycle where a register-A or register-B clear is applied, and `tcnt` reads 0 on the following edge.
- R12: When a clear and a tick coincide, the clear wins.
- R13: `gr_we[i]` loads `gr_wdata` into register i. A capture in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control write data: clear[6:5], edge[4:3], prescaler[2:0] |
| cfg_rdata | output | 8 | Control readback, bit 7 reads 0 |
| gr_we | input | 2 | Write strobes for general registers (bit 0 = A, bit 1 = B) |
| gr_wdata | input | 16 | General register write data |
| gr_cap_mode | input | 2 | Role per register: 0 compare, 1 capture |
| cap_strobe | input | 2 | Synchronous one-cycle capture requests |
| int_clk | input | 4 | Internal prescaled clock levels, synchronous to clk |
| ext_clk | input | 4 | External clock pins, asynchronous |
| phase_mode | input | 1 | Phase-counting override |
| phase_tick | input | 1 | Count tick from the phase decoder |
| sync_clr_in | input | 1 | Clear pulse from a peer channel |
| tcnt | output | 16 | Counter value |
| gra | output | 16 | General register A |
| grb | output | 16 | General register B |
| cmp_match | output | 2 | Compare-match flags (bit 0 = A, bit 1 = B) |
| clr_evt | output | 1 | Register-caused clear pulse for peers |

## Verification
The bench goes through all four clear selections and shows that only 01 and 10 fold the counter back, each at its own register's value. A design that decoded the field wrongly would clear at the wrong count or never. It checks all edge selections on an external pin, so a design that counted both edges in a single-edge mode would report double counts. It checks that a rising internal edge is not counted and that pin and field changes under the phase override leave the counter still, where a leak in the override would show as extra counts. Capture is checked for returning the value before the clear and for beating a simultaneous write. The wrap at 0xFFFF and the silence of `clr_evt` in synchronized mode are also checked, and either fault would appear as a wrong counter value or a spurious pulse.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_GRA  = 2'b01,
    CLR_GRB  = 2'b10,
    CLR_SYNC = 2'b11
  } clr_sel_e;

  typedef struct packed {
    clr_sel_e   clr_sel;
    logic [1:0] edge_sel;
    logic [2:0] psc;
  } ctl_t;

  localparam int GR_NUM = 2;
  localparam int CTL_W  = $bits(ctl_t);

endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<SEL_W)-1:0]   int_clk,
  input  logic [(1<<SEL_W)-1:0]   ext_clk,
  input  logic [SEL_W:0]          psc,
  input  logic [1:0]              edge_sel,
  input  logic                    phase_mode,
  input  logic                    phase_tick,
  output logic                    tick
);

  localparam int N_SRC = 1 << SEL_W;

  logic [N_SRC-1:0][SYNC_STAGES-1:0] ext_sync_q, ext_sync_d;
  logic [N_SRC-1:0]                  ext_now;
  logic [N_SRC-1:0]                  ext_prev_q;
  logic [N_SRC-1:0]                  int_prev_q;

  for (genvar p = 0; p < N_SRC; p++) begin : g_pin
    assign ext_sync_d[p] = {ext_sync_q[p][SYNC_STAGES-2:0], ext_clk[p]};
    assign ext_now[p]    = ext_sync_q[p][SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync_q <= '0;
      ext_prev_q <= '0;
      int_prev_q <= '0;
    end else begin
      ext_sync_q <= ext_sync_d;
      ext_prev_q <= ext_now;
      int_prev_q <= int_clk;
    end
  end

  logic [SEL_W-1:0] sel;
  logic             int_fall, ext_rise, ext_fall, ext_tick;

  always_comb begin
    sel      = psc[SEL_W-1:0];
    int_fall = int_prev_q[sel] & ~int_clk[sel];
    ext_rise = ~ext_prev_q[sel] & ext_now[sel];
    ext_fall = ext_prev_q[sel] & ~ext_now[sel];
    if (edge_sel[1])      ext_tick = ext_rise | ext_fall;
    else if (edge_sel[0]) ext_tick = ext_fall;
    else                  ext_tick = ext_rise;
    if (phase_mode)       tick = phase_tick;
    else if (psc[SEL_W])  tick = ext_tick;
    else                  tick = int_fall;
  end

endmodule

// File: rtl/tmr_gr.sv
module tmr_gr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_mode,
  input  logic             cap_stb,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] tcnt,
  input  logic             tick,
  output logic [CNT_W-1:0] gr_q,
  output logic             match,
  output logic             clr_req
);

  logic [CNT_W-1:0] gr_d;
  logic             cap_hit;

  always_comb begin
    cap_hit = cap_mode & cap_stb;
    if (cap_hit)    gr_d = tcnt;
    else if (wr_en) gr_d = wr_data;
    else            gr_d = gr_q;
    match   = ~cap_mode & (tcnt == gr_q);
    clr_req = cap_mode ? cap_stb : (match & tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gr_q <= '1;
    else        gr_q <= gr_d;
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [6:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic [1:0]            gr_we,
  input  logic [CNT_W-1:0]      gr_wdata,
  input  logic [1:0]            gr_cap_mode,
  input  logic [1:0]            cap_strobe,
  input  logic [(1<<SEL_W)-1:0] int_clk,
  input  logic [(1<<SEL_W)-1:0] ext_clk,
  input  logic                  phase_mode,
  input  logic                  phase_tick,
  input  logic                  sync_clr_in,
  output logic [CNT_W-1:0]      tcnt,
  output logic [CNT_W-1:0]      gra,
  output logic [CNT_W-1:0]      grb,
  output logic [1:0]            cmp_match,
  output logic                  clr_evt
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // control register
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = cfg_we ? ctl_t'(cfg_wdata[CTL_W-1:0]) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ctl_q <= '0;
    else             ctl_q <= ctl_d;
  end

  assign cfg_rdata = {1'b0, ctl_q};

  logic [1:0] clr_sel_w;
  assign clr_sel_w = ctl_q.clr_sel;

  // count tick
  logic tick;

  tmr_clk_sel #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .int_clk    (int_clk),
    .ext_clk    (ext_clk),
    .psc        (ctl_q.psc[SEL_W:0]),
    .edge_sel   (ctl_q.edge_sel),
    .phase_mode (phase_mode),
    .phase_tick (phase_tick),
    .tick       (tick)
  );

  // general registers
  logic [GR_NUM-1:0][CNT_W-1:0] gr_q;
  logic [GR_NUM-1:0]            gr_clr_req;

  for (genvar g = 0; g < GR_NUM; g++) begin : g_gr
    tmr_gr #(.CNT_W(CNT_W)) u_gr (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .cap_mode (gr_cap_mode[g]),
      .cap_stb  (cap_strobe[g]),
      .wr_en    (gr_we[g]),
      .wr_data  (gr_wdata),
      .tcnt     (tcnt),
      .tick     (tick),
      .gr_q     (gr_q[g]),
      .match    (cmp_match[g]),
      .clr_req  (gr_clr_req[g])
    );
  end

  assign gra = gr_q[0];
  assign grb = gr_q[1];

  // counter
  logic             cnt_clr, gr_clr;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    gr_clr  = ((ctl_q.clr_sel == CLR_GRA) & gr_clr_req[0])
            | ((ctl_q.clr_sel == CLR_GRB) & gr_clr_req[1]);
    cnt_clr = gr_clr | ((ctl_q.clr_sel == CLR_SYNC) & sync_clr_in);
    if (cnt_clr)   cnt_d = '0;
    else if (tick) cnt_d = tcnt + CNT_W'(1);
    else           cnt_d = tcnt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tcnt <= '0;
    else             tcnt <= cnt_d;
  end

  assign clr_evt = gr_clr;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       clr_sel,
  input logic [1:0]       gr_cap_mode,
  input logic [1:0]       cap_strobe,
  input logic [1:0]       cmp_match,
  input logic             tick,
  input logic             cnt_clr,
  input logic             clr_evt,
  input logic             sync_clr_in,
  input logic [CNT_W-1:0] tcnt,
  input logic [CNT_W-1:0] gra,
  input logic [CNT_W-1:0] grb,
  input logic             rd_msb
);

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clr) |=> tcnt == CNT_W'($past(tcnt) + 1'b1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clr) |=> $stable(tcnt));

  a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> tcnt == '0);

  a_r7_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 2'b00) |-> !cnt_clr);

  a_r8_cmp_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 2'b01 && !gr_cap_mode[0] && cmp_match[0] && tick) |-> cnt_clr);

  a_r9_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_cap_mode[0] && cap_strobe[0]) |=> gra == $past(tcnt));

  a_r9_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_cap_mode[1] && cap_strobe[1]) |=> grb == $past(tcnt));

  a_r10_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 2'b11 && sync_clr_in) |-> (cnt_clr && !clr_evt));

  a_r11_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> (clr_sel == 2'b01 || clr_sel == 2'b10));

  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_msb == 1'b0);

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .clr_sel     (clr_sel_w),
  .gr_cap_mode (gr_cap_mode),
  .cap_strobe  (cap_strobe),
  .cmp_match   (cmp_match),
  .tick        (tick),
  .cnt_clr     (cnt_clr),
  .clr_evt     (clr_evt),
  .sync_clr_in (sync_clr_in),
  .tcnt        (tcnt),
  .gra         (gra),
  .grb         (grb),
  .rd_msb      (cfg_rdata[7])
);

// File: tb/tmr_chan_tb.sv
`timescale 1ns/1ps
module tmr_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [1:0]  gr_we;
  logic [15:0] gr_wdata;
  logic [1:0]  gr_cap_mode;
  logic [1:0]  cap_strobe;
  logic [3:0]  int_clk;
  logic [3:0]  ext_clk;
  logic        phase_mode;
  logic        phase_tick;
  logic        sync_clr_in;
  logic [15:0] tcnt, gra, grb;
  logic [1:0]  cmp_match;
  logic        clr_evt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gr_we(gr_we), .gr_wdata(gr_wdata),
    .gr_cap_mode(gr_cap_mode), .cap_strobe(cap_strobe), .int_clk(int_clk),
    .ext_clk(ext_clk), .phase_mode(phase_mode), .phase_tick(phase_tick),
    .sync_clr_in(sync_clr_in), .tcnt(tcnt), .gra(gra), .grb(grb),
    .cmp_match(cmp_match), .clr_evt(clr_evt)
  );

  // {edge_sel[1:0], pulses[3:0], expected_count[7:0]}
  localparam logic [13:0] EDGE_VEC [4] = '{
    {2'b00, 4'd3, 8'd3},
    {2'b01, 4'd3, 8'd3},
    {2'b10, 4'd3, 8'd6},
    {2'b11, 4'd2, 8'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [6:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic wr_gr(input int idx, input logic [15:0] v);
    gr_we[idx] = 1'b1; gr_wdata = v;
    cyc(1);
    gr_we = '0;
  endtask

  task automatic ptick(output logic evt);
    phase_tick = 1'b1;
    #1 evt = clr_evt;
    cyc(1);
    phase_tick = 1'b0;
  endtask

  task automatic zero_cnt();
    wr_cfg(7'b11_00_000);
    sync_clr_in = 1'b1;
    cyc(1);
    sync_clr_in = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    logic        evt, seen;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; gr_we = '0; gr_wdata = '0;
    gr_cap_mode = '0; cap_strobe = '0; int_clk = '0; ext_clk = '0;
    phase_mode = 1'b0; phase_tick = 1'b0; sync_clr_in = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    chk("R1 tcnt", tcnt, 0);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 gra", gra, 16'hFFFF);
    chk("R1 grb", grb, 16'hFFFF);
    chk("R1 flags", {cmp_match, clr_evt}, 0);

    // R2 register readback, bit 7 reads 0
    wr_cfg(7'h7F);
    chk("R2 readback", cfg_rdata, 8'h7F);
    wr_cfg(7'h00);
    chk("R2 cleared", cfg_rdata, 8'h00);

    // R4 edge selection on external pin 1, table driven
    for (int i = 0; i < 4; i++) begin
      wr_cfg({2'b00, EDGE_VEC[i][13:12], 3'b101});
      cyc(4);
      base = tcnt;
      for (int p = 0; p < int'(EDGE_VEC[i][11:8]); p++) begin
        ext_clk[1] = 1'b1; cyc(4);
        ext_clk[1] = 1'b0; cyc(4);
      end
      chk($sformatf("R4 edge_sel=%0b", EDGE_VEC[i][13:12]), tcnt - base, {8'd0, EDGE_VEC[i][7:0]});
    end

    // R3 internal clock: falling edges only, selected pin only
    wr_cfg(7'b00_00_010);
    cyc(3);
    base = tcnt;
    int_clk[2] = 1'b1; cyc(3);
    chk("R3 rise ignored", tcnt - base, 0);
    int_clk[2] = 1'b0; cyc(3);
    chk("R3 fall counted", tcnt - base, 1);
    int_clk[1] = 1'b1; cyc(2); int_clk[1] = 1'b0; cyc(3);
    chk("R3 other pin ignored", tcnt - base, 1);

    // R5 phase override masks prescaler and edge fields
    phase_mode = 1'b1;
    cyc(2);
    base = tcnt;
    int_clk[2] = 1'b1; cyc(2); int_clk[2] = 1'b0; cyc(3);
    chk("R5 internal masked", tcnt - base, 0);
    wr_cfg(7'b00_11_001);
    ext_clk[1] = 1'b1; cyc(4); ext_clk[1] = 1'b0; cyc(4);
    chk("R5 prescaler change masked", tcnt - base, 0);
    ptick(evt); cyc(1);
    chk("R5 phase tick counts", tcnt - base, 1);

    // R7 R8 R10 R11 every clear selection, GRA=3 GRB=5 in compare mode
    wr_gr(0, 16'd3);
    wr_gr(1, 16'd5);
    for (int c = 0; c < 4; c++) begin
      zero_cnt();
      wr_cfg({c[1:0], 5'b00_000});
      seen = 1'b0;
      for (int t = 0; t < 6; t++) begin
        ptick(evt);
        seen |= evt;
      end
      case (c)
        0: chk("R7 no clear", tcnt, 6);
        1: chk("R8 clear on A", tcnt, 2);
        2: chk("R8 clear on B", tcnt, 0);
        default: chk("R10 sync mode no self clear", tcnt, 6);
      endcase
      chk($sformatf("R11 evt cclr=%0d", c), seen, (c == 1 || c == 2));
    end

    // R8 match flags follow the counter
    zero_cnt();
    wr_cfg(7'b00_00_000);
    repeat (3) ptick(evt);
    chk("R8 match A", cmp_match, 2'b01);
    repeat (2) ptick(evt);
    chk("R8 match B", cmp_match, 2'b10);

    // R12 clear beats tick: A at 3, tick while matching gives 0 not 4
    zero_cnt();
    wr_cfg(7'b01_00_000);
    repeat (3) ptick(evt);
    ptick(evt);
    chk("R12 clear wins", tcnt, 0);
    chk("R11 evt with clear", evt, 1);

    // R10 sync pulse ignored outside sync mode
    repeat (2) ptick(evt);
    sync_clr_in = 1'b1; cyc(1); sync_clr_in = 1'b0;
    chk("R10 sync ignored", tcnt, 2);

    // R9 capture on A with clear on A
    zero_cnt();
    gr_cap_mode = 2'b01;
    wr_cfg(7'b01_00_000);
    repeat (5) ptick(evt);
    chk("R9 no match in capture", cmp_match[0], 0);
    cap_strobe[0] = 1'b1;
    #1 evt = clr_evt;
    cyc(1);
    cap_strobe[0] = 1'b0;
    chk("R9 capture value", gra, 5);
    chk("R9 clear after capture", tcnt, 0);
    chk("R11 capture evt", evt, 1);

    // R13 capture beats write
    repeat (2) ptick(evt);
    cap_strobe[0] = 1'b1; gr_we[0] = 1'b1; gr_wdata = 16'h1234;
    cyc(1);
    cap_strobe[0] = 1'b0; gr_we = '0;
    chk("R13 capture over write", gra, 2);
    gr_cap_mode = 2'b00;
    wr_gr(1, 16'hABCD);
    chk("R13 plain write", grb, 16'hABCD);

    // R9 capture on B without clear
    gr_cap_mode = 2'b10;
    wr_cfg(7'b00_00_000);
    repeat (4) ptick(evt);
    base = tcnt;
    cap_strobe[1] = 1'b1;
    #1 evt = clr_evt;
    cyc(1);
    cap_strobe[1] = 1'b0;
    chk("R9 capture B", grb, base);
    chk("R9 counter kept", tcnt, base);
    chk("R11 no evt when unselected", evt, 0);
    gr_cap_mode = 2'b00;

    // R6 wrap
    wr_gr(0, 16'h0000);
    zero_cnt();
    wr_cfg(7'b00_00_000);
    phase_tick = 1'b1;
    cyc(65535);
    chk("R6 reach max", tcnt, 16'hFFFF);
    cyc(1);
    phase_tick = 1'b0;
    chk("R6 wrap", tcnt, 16'h0000);
    cyc(2);
    chk("R6 hold", tcnt, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule